// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps one write-back cache coherent with the other caches that share a single bus. Each line of a small direct-mapped store is marked Invalid, Clean or Dirty. Reads that hit, and writes that hit a Dirty line, finish in the cycle they are presented and cause no bus traffic. Any other CPU access becomes a bus transaction. The controller requests the bus and waits for grant. Once it holds the bus it writes back a dirty victim if one must be replaced. It then places a read-miss or write-miss command on the bus, waits for the fill, and releases the bus in the cycle it answers the CPU. From grant to release the transaction is never interrupted.

While another master drives the bus, the controller watches its read-miss and write-miss commands. A Dirty line that is named by one of these commands supplies its data and inhibits main memory. A snooped write miss invalidates the named line. A snooped read miss demotes a Dirty line to Clean and leaves a Clean line as it is. Snoops are still serviced while a CPU miss waits for grant. After grant the pending request is judged again against the current line state, so a write that was about to upgrade a Clean line becomes a full write miss if a snoop has invalidated that line in the meantime. The arbiter, main memory and the other caches live in the environment.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid. cpu_ready, bus_req and mem_inhibit are low and bus_cmd_o is 2'b00 (none).
- R2: A read whose tag matches a Clean or Dirty line, or a write whose tag matches a Dirty line, raises cpu_ready in the same cycle and never raises bus_req. A read returns the line data on cpu_rdata, and a write stores cpu_wdata.
- R3: A read miss raises bus_req. After grant it drives bus_cmd_o = 2'b01 (read miss) with bus_addr_o = cpu_addr for one cycle. After fill_valid the line is Clean and holds fill_data, and the next cycle shows cpu_ready with that data. The address splits into index = addr[IDXW-1:0] and tag = the upper bits.
- R4: A write miss drives bus_cmd_o = 2'b10 (write miss) and waits for the fill. The line is then Dirty and holds cpu_wdata, not fill_data.
- R5: A write to a Clean line with a matching tag drives bus_cmd_o = 2'b10 after grant, needs no fill, marks the line Dirty and raises cpu_ready in the following cycle.
- R6: A miss that maps onto a Dirty line holding another tag first drives bus_cmd_o = 2'b11 (data) with mem_inhibit low, carrying the victim's address and data. The miss command follows in the next cycle.
- R7: A snooped read miss that hits a Dirty line drives, in the next cycle, bus_cmd_o = 2'b11 with the line data and mem_inhibit high, and leaves the line Clean. A snooped read miss that hits a Clean line gives no response and leaves the line unchanged.
- R8: A snooped write miss leaves a Clean or Dirty line Invalid. A Dirty line also supplies its data with mem_inhibit high in the next cycle.
- R9: A snoop command that arrives while this controller owns the bus (write-back, miss or fill phase) changes no line and produces no response.
- R10: Snoops are serviced while a request waits for grant, and grant is not accepted in a cycle that carries a snoop command or a data response. After grant the request is classified again from the current line state.
- R11: A CPU request whose index equals that of a snoop being serviced in the same cycle is held with cpu_ready low for that cycle and is evaluated in the next.
- R12: bus_req drops exactly in the cycle in which cpu_ready completes a bus transaction, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Access address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Access complete |
| cpu_rdata | output | DW | Read data of the addressed line |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd_o | output | 2 | Command driven: 00 none, 01 read miss, 10 write miss, 11 data |
| bus_addr_o | output | AW | Address for the driven command |
| bus_data_o | output | DW | Write-back or supplied data |
| mem_inhibit | output | 1 | Main memory must not respond; this cache supplies the data |
| snp_cmd_i | input | 2 | Snooped command from another master, same encoding |
| snp_addr_i | input | AW | Snooped address |
| fill_valid | input | 1 | Fill data for the pending miss is present |
| fill_data | input | DW | Fill data |

## Verification
Two functions can meet in one cycle. One is a CPU lookup against the store and the other is a snoop update of the same line. The bench presents a read hit together with a snooped read miss to the same index and expects one stall cycle, then a hit with no bus request. A second collision comes from a snooped write miss that invalidates a Clean line while a write upgrade to that line waits for grant. The bench judges this case by the cycle in which cpu_ready rises. An upgrade would answer one cycle after the miss command, but the correct re-evaluated full write miss must wait for fill and answer two cycles after it. A snoop placed inside the bench's own write-back phase must produce no mem_inhibit pulse.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_CLN = 2'd1,
        LN_DRT = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_DATA   = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_REQ,
        F_WB,
        F_MISS,
        F_FILL,
        F_DONE
    } fsm_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int IDXW = 2,
    parameter int TAGW = 6,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] a_idx,
    output logic [TAGW-1:0] a_tag,
    output line_st_e        a_st,
    output logic [DW-1:0]   a_data,
    input  logic [IDXW-1:0] b_idx,
    output logic [TAGW-1:0] b_tag,
    output line_st_e        b_st,
    output logic [DW-1:0]   b_data,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [TAGW-1:0] wr_tag,
    input  line_st_e        wr_st,
    input  logic [DW-1:0]   wr_data,
    input  logic            snp_en,
    input  logic [IDXW-1:0] snp_idx,
    input  line_st_e        snp_st
);
    localparam int LINES = 1 << IDXW;

    typedef struct packed {
        logic [TAGW-1:0] tag;
        line_st_e        st;
        logic [DW-1:0]   data;
    } line_t;

    line_t lines [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (wr_en && wr_idx == IDXW'(i)) begin
                line_d.tag  = wr_tag;
                line_d.st   = wr_st;
                line_d.data = wr_data;
            end else if (snp_en && snp_idx == IDXW'(i)) begin
                line_d.st = snp_st;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '{tag: '0, st: LN_INV, data: '0};
            end else begin
                line_q <= line_d;
            end
        end

        assign lines[i] = line_q;
    end

    assign a_tag  = lines[a_idx].tag;
    assign a_st   = lines[a_idx].st;
    assign a_data = lines[a_idx].data;
    assign b_tag  = lines[b_idx].tag;
    assign b_st   = lines[b_idx].st;
    assign b_data = lines[b_idx].data;

endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
    import coh_pkg::*;
#(
    parameter int TAGW = 6
) (
    input  logic            active,
    input  bus_cmd_e        cmd,
    input  logic [TAGW-1:0] snp_tag,
    input  logic [TAGW-1:0] line_tag,
    input  line_st_e        line_st,
    output logic            upd_en,
    output line_st_e        upd_st,
    output logic            supply
);
    logic hit;

    always_comb begin
        hit    = active && (line_st != LN_INV) && (line_tag == snp_tag);
        upd_en = 1'b0;
        upd_st = line_st;
        supply = 1'b0;
        if (hit) begin
            case (cmd)
                BC_RDMISS: begin
                    if (line_st == LN_DRT) begin
                        upd_en = 1'b1;
                        upd_st = LN_CLN;
                        supply = 1'b1;
                    end
                end
                BC_WRMISS: begin
                    upd_en = 1'b1;
                    upd_st = LN_INV;
                    supply = (line_st == LN_DRT);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int AW   = 8,
    parameter int IDXW = 2,
    parameter int DW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    bus_cmd_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_data_o,
    output logic          mem_inhibit,
    input  logic [1:0]    snp_cmd_i,
    input  logic [AW-1:0] snp_addr_i,
    input  logic          fill_valid,
    input  logic [DW-1:0] fill_data
);
    localparam int TAGW = AW - IDXW;

    typedef struct packed {
        fsm_e          fsm;
        logic          sup;
        logic [DW-1:0] sup_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDXW-1:0] cpu_idx, snp_idx;
    logic [TAGW-1:0] cpu_tag, snp_tag;
    logic [TAGW-1:0] a_tag, b_tag;
    line_st_e        a_st, b_st;
    logic [DW-1:0]   a_data, b_data;

    logic            wr_en;
    line_st_e        wr_st;
    logic [DW-1:0]   wr_data;
    logic            snp_upd_en, snp_supply;
    line_st_e        snp_upd_st;
    logic            owning, snp_act, snp_same;
    logic            tag_hit, hit_ok, victim, upgrade;
    bus_cmd_e        snp_cmd, cmd_d;

    assign cpu_idx = cpu_addr[IDXW-1:0];
    assign cpu_tag = cpu_addr[AW-1:IDXW];
    assign snp_idx = snp_addr_i[IDXW-1:0];
    assign snp_tag = snp_addr_i[AW-1:IDXW];
    assign snp_cmd = bus_cmd_e'(snp_cmd_i);

    coh_line_store #(.IDXW(IDXW), .TAGW(TAGW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (cpu_idx),
        .a_tag   (a_tag),
        .a_st    (a_st),
        .a_data  (a_data),
        .b_idx   (snp_idx),
        .b_tag   (b_tag),
        .b_st    (b_st),
        .b_data  (b_data),
        .wr_en   (wr_en),
        .wr_idx  (cpu_idx),
        .wr_tag  (cpu_tag),
        .wr_st   (wr_st),
        .wr_data (wr_data),
        .snp_en  (snp_upd_en),
        .snp_idx (snp_idx),
        .snp_st  (snp_upd_st)
    );

    coh_snoop_resp #(.TAGW(TAGW)) u_snoop (
        .active   (snp_act),
        .cmd      (snp_cmd),
        .snp_tag  (snp_tag),
        .line_tag (b_tag),
        .line_st  (b_st),
        .upd_en   (snp_upd_en),
        .upd_st   (snp_upd_st),
        .supply   (snp_supply)
    );

    always_comb begin
        r_d        = r_q;
        owning     = (r_q.fsm == F_WB) || (r_q.fsm == F_MISS) || (r_q.fsm == F_FILL);
        snp_act    = (snp_cmd != BC_NONE) && !owning;
        snp_same   = snp_act && (snp_idx == cpu_idx);
        tag_hit    = (a_tag == cpu_tag);
        hit_ok     = (a_st != LN_INV) && tag_hit && (!cpu_we || a_st == LN_DRT);
        victim     = (a_st == LN_DRT) && !tag_hit;
        upgrade    = cpu_we && tag_hit && (a_st == LN_CLN);

        wr_en      = 1'b0;
        wr_st      = cpu_we ? LN_DRT : LN_CLN;
        wr_data    = cpu_we ? cpu_wdata : fill_data;
        cpu_ready  = 1'b0;
        bus_req    = 1'b0;
        cmd_d      = BC_NONE;
        bus_addr_o = '0;
        bus_data_o = '0;

        r_d.sup      = snp_supply;
        r_d.sup_data = b_data;

        case (r_q.fsm)
            F_IDLE: begin
                if (cpu_req && !snp_same) begin
                    if (hit_ok) begin
                        cpu_ready = 1'b1;
                        wr_en     = cpu_we;
                    end else begin
                        r_d.fsm = F_REQ;
                    end
                end
            end
            F_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt && snp_cmd == BC_NONE && !r_q.sup) begin
                    r_d.fsm = victim ? F_WB : F_MISS;
                end
            end
            F_WB: begin
                bus_req    = 1'b1;
                cmd_d      = BC_DATA;
                bus_addr_o = {a_tag, cpu_idx};
                bus_data_o = a_data;
                r_d.fsm    = F_MISS;
            end
            F_MISS: begin
                bus_req    = 1'b1;
                cmd_d      = cpu_we ? BC_WRMISS : BC_RDMISS;
                bus_addr_o = cpu_addr;
                if (upgrade) begin
                    wr_en   = 1'b1;
                    r_d.fsm = F_DONE;
                end else begin
                    r_d.fsm = F_FILL;
                end
            end
            F_FILL: begin
                bus_req = 1'b1;
                if (fill_valid) begin
                    wr_en   = 1'b1;
                    r_d.fsm = F_DONE;
                end
            end
            F_DONE: begin
                cpu_ready = 1'b1;
                r_d.fsm   = F_IDLE;
            end
            default: r_d.fsm = F_IDLE;
        endcase

        if (r_q.sup) begin
            cmd_d      = BC_DATA;
            bus_data_o = r_q.sup_data;
        end
    end

    assign bus_cmd_o   = cmd_d;
    assign mem_inhibit = r_q.sup;
    assign cpu_rdata   = a_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{fsm: F_IDLE, sup: 1'b0, sup_data: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/coh_chk.sv
module coh_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req,
    input logic       cpu_ready,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd_o,
    input logic [1:0] snp_cmd_i,
    input logic       mem_inhibit
);
    // R7: a supply pulse always carries the data command
    assert_inhibit_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> bus_cmd_o == 2'b11);

    // R8: memory is only inhibited one cycle after a snooped command
    assert_inhibit_after_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> $past(snp_cmd_i) != 2'b00);

    // R9: own commands only while holding the bus
    assert_cmd_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != 2'b00 && !mem_inhibit) |-> (bus_req && bus_gnt));

    // R12: bus released only when the transaction completes
    assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> cpu_ready);

    // R2: completion only answers a present request
    assert_ready_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

bind snoop_coh_ctrl coh_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_ready   (cpu_ready),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd_o   (bus_cmd_o),
    .snp_cmd_i   (snp_cmd_i),
    .mem_inhibit (mem_inhibit)
);

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [1:0]  bus_cmd_o;
    logic [7:0]  bus_addr_o;
    logic [15:0] bus_data_o;
    logic        mem_inhibit;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    snoop_coh_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o),
        .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .mem_inhibit(mem_inhibit),
        .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // one CPU access, answered like an arbiter and memory would
    task automatic txn(input logic we, input logic [7:0] addr, input logic [15:0] wd,
                       input logic [15:0] fd, input int gnt_at, input int snp_at,
                       input logic [1:0] scmd, input logic [7:0] saddr,
                       output int rit, output logic [15:0] rd, output logic swb,
                       output logic [7:0] wba, output logic [15:0] wbd,
                       output logic [1:0] mc, output logic [7:0] ma,
                       output logic ssup, output logic sbreq);
        logic give, prev;
        rit = -1; rd = '0; swb = 0; wba = '0; wbd = '0; mc = '0; ma = '0;
        ssup = 0; sbreq = 0; give = 0; prev = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        for (int it = 0; it < 30; it++) begin
            fill_valid = give; fill_data = fd; give = 0;
            snp_cmd  = (it == snp_at) ? scmd : 2'b00;
            snp_addr = saddr;
            #1;
            if (bus_req) sbreq = 1;
            if (bus_req && it >= gnt_at) bus_gnt = 1'b1;
            if (bus_cmd_o == 2'b11 && !mem_inhibit) begin
                swb = 1; wba = bus_addr_o; wbd = bus_data_o;
            end
            if (mem_inhibit) ssup = 1;
            if (bus_cmd_o == 2'b01 || bus_cmd_o == 2'b10) begin
                mc = bus_cmd_o; ma = bus_addr_o; give = 1;
            end
            if (cpu_ready) begin
                rit = it; rd = cpu_rdata;
                if (sbreq) chk(!bus_req && prev, "R12 release with ready", {bus_req, prev}, 2'b01);
                break;
            end
            prev = bus_req;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0; fill_valid = 1'b0; snp_cmd = 2'b00;
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr,
                         output logic sup, output logic [15:0] sd);
        @(negedge clk);
        snp_cmd = cmd; snp_addr = addr;
        #1;
        @(negedge clk);
        snp_cmd = 2'b00;
        #1;
        sup = mem_inhibit && (bus_cmd_o == 2'b11);
        sd  = bus_data_o;
    endtask

    int          rit;
    logic [15:0] rd, wbd, sd;
    logic        swb, ssup, sbreq, sup;
    logic [7:0]  wba, ma;
    logic [1:0]  mc;

    task automatic t_reset;
        repeat (3) @(negedge clk);
        #1;
        chk(!cpu_ready && !bus_req && !mem_inhibit && bus_cmd_o == 2'b00, "R1 reset outputs",
            {cpu_ready, bus_req, mem_inhibit, bus_cmd_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_read_miss;
        txn(0, 8'h14, 0, 16'hAAAA, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(mc == 2'b01 && ma == 8'h14, "R3 read-miss command", {mc, ma}, {2'b01, 8'h14});
        chk(rit == 4 && rd == 16'hAAAA && !swb, "R3 fill and ready", {rit, rd}, {32'd4, 16'hAAAA});
        chk(sbreq, "R1 line invalid after reset", sbreq, 1);
    endtask

    task automatic t_hits;
        txn(0, 8'h14, 0, 0, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(rit == 0 && rd == 16'hAAAA && !sbreq, "R2 read hit Clean", {rit, rd, sbreq}, {32'd0, 16'hAAAA, 1'b0});
        txn(1, 8'h14, 16'h1111, 0, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(mc == 2'b10 && ma == 8'h14 && rit == 3 && rd == 16'h1111, "R5 write upgrade",
            {mc, ma, rit, rd}, {2'b10, 8'h14, 32'd3, 16'h1111});
        txn(1, 8'h14, 16'h2222, 0, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(rit == 0 && !sbreq, "R2 write hit Dirty", {rit, sbreq}, {32'd0, 1'b0});
        txn(0, 8'h14, 0, 0, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(rit == 0 && rd == 16'h2222, "R2 read hit Dirty data", {rit, rd}, {32'd0, 16'h2222});
    endtask

    task automatic t_evict;
        txn(0, 8'h24, 0, 16'hBBBB, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(swb && wba == 8'h14 && wbd == 16'h2222, "R6 write-back of victim", {swb, wba, wbd}, {1'b1, 8'h14, 16'h2222});
        chk(mc == 2'b01 && ma == 8'h24 && rit == 5 && rd == 16'hBBBB, "R6 miss after write-back",
            {mc, ma, rit, rd}, {2'b01, 8'h24, 32'd5, 16'hBBBB});
    endtask

    task automatic t_write_miss;
        txn(1, 8'h35, 16'h3333, 16'h9999, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(mc == 2'b10 && ma == 8'h35 && rit == 4 && rd == 16'h3333, "R4 write miss",
            {mc, ma, rit, rd}, {2'b10, 8'h35, 32'd4, 16'h3333});
    endtask

    task automatic t_snoop_read;
        snoop(2'b01, 8'h35, sup, sd);
        chk(sup && sd == 16'h3333, "R7 Dirty supplies on read miss", {sup, sd}, {1'b1, 16'h3333});
        txn(1, 8'h35, 16'h4444, 0, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(mc == 2'b10 && rit == 3, "R7 line demoted to Clean", {mc, rit}, {2'b10, 32'd3});
        snoop(2'b01, 8'h24, sup, sd);
        chk(!sup, "R7 Clean gives no response", sup, 0);
        txn(0, 8'h24, 0, 0, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(rit == 0 && rd == 16'hBBBB, "R7 Clean stays Clean", {rit, rd}, {32'd0, 16'hBBBB});
    endtask

    task automatic t_snoop_write;
        snoop(2'b10, 8'h35, sup, sd);
        chk(sup && sd == 16'h4444, "R8 Dirty supplies on write miss", {sup, sd}, {1'b1, 16'h4444});
        txn(0, 8'h35, 0, 16'h5555, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(mc == 2'b01 && rit == 4 && rd == 16'h5555 && !swb, "R8 Dirty invalidated",
            {mc, rit, rd}, {2'b01, 32'd4, 16'h5555});
        snoop(2'b10, 8'h24, sup, sd);
        chk(!sup, "R8 Clean gives no data", sup, 0);
        txn(0, 8'h24, 0, 16'h6666, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(mc == 2'b01 && rit == 4 && rd == 16'h6666, "R8 Clean invalidated", {mc, rit, rd}, {2'b01, 32'd4, 16'h6666});
    endtask

    task automatic t_own_ignore;
        txn(1, 8'h0A, 16'h0A0A, 0, 0, -1, 0, 0, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(rit == 4 && rd == 16'h0A0A, "R4 write miss second line", {rit, rd}, {32'd4, 16'h0A0A});
        txn(0, 8'h1A, 0, 16'h1A1A, 0, 2, 2'b10, 8'h0A, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(swb && wba == 8'h0A && wbd == 16'h0A0A && !ssup, "R9 snoop ignored while owning",
            {swb, wba, wbd, ssup}, {1'b1, 8'h0A, 16'h0A0A, 1'b0});
        chk(rit == 5 && rd == 16'h1A1A, "R9 transaction unbroken", {rit, rd}, {32'd5, 16'h1A1A});
    endtask

    task automatic t_reeval;
        txn(1, 8'h24, 16'h7777, 16'hCCCC, 2, 1, 2'b10, 8'h24, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(mc == 2'b10 && rit == 5 && rd == 16'h7777, "R10 upgrade re-evaluated to full miss",
            {mc, rit, rd}, {2'b10, 32'd5, 16'h7777});
    endtask

    task automatic t_collision;
        txn(0, 8'h35, 0, 0, 0, 0, 2'b01, 8'h35, rit, rd, swb, wba, wbd, mc, ma, ssup, sbreq);
        chk(rit == 1 && rd == 16'h5555 && !sbreq, "R11 same-index stall", {rit, rd, sbreq}, {32'd1, 16'h5555, 1'b0});
    endtask

    initial begin
        t_reset();
        t_read_miss();
        t_hits();
        t_evict();
        t_write_miss();
        t_snoop_read();
        t_snoop_write();
        t_own_ignore();
        t_reeval();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule